// File: doc/BRIEF.md
# Exception entry sequencer

This block takes a 32-bit processor core into any exception other than reset. The core raises a request and supplies its live status register, program counter, supervisor stack pointer and vector base register. It also says whether the exception is an interrupt, with its level, or an internal event, with its vector number. The sequencer keeps a private copy of the status word. It then raises the privilege of the live copy and turns off tracing. It gets the vector number, either from an interrupt-acknowledge read or from the internal input.

All memory traffic uses one 16-bit port with a request/acknowledge handshake. The block writes a four-word frame onto the supervisor stack. It then reads the handler address from the vector table in two halves. Once the program counter holds the handler address, it pulses `done`. If the interrupt-acknowledge read ends in a bus error, the sequencer raises `error` and returns to idle. In that case it writes no frame and leaves the program counter alone.

Top module: `exc_entry_seq`

## Requirements
- R1: A request is taken only while `busy` is low. `busy` is high from the cycle after acceptance until the cycle `done` or `error` rises. A request seen while busy starts nothing.
- R2: The live status word `sr_out` is the accepted status word with bit 13 (supervisor) set, bits 15 and 14 (trace) cleared, and bits 12:11 and 7:0 unchanged.
- R3: For an interrupt, `sr_out[10:8]` takes the interrupt level. For an internal exception those bits keep their accepted value.
- R4: An interrupt runs exactly one read with function code 7 at address `0x000F0000 | level<<1 | 1`, and bits 7:0 of the read data are the vector number. An internal exception runs no such read and uses `int_vector`.
- R5: The frame is four writes with function code 5, made in this order: format word to SSP-2, PC[15:0] to SSP-4, PC[31:16] to SSP-6, and the accepted (unmodified) status word to SSP-8.
- R6: The format word has format code 0000 in bits 15:12 and the vector number times four in bits 11:0.
- R7: Once raised, `bus_req` with its address, direction, function code and write data stays unchanged until a cycle with `bus_ack` high.
- R8: After the frame, two reads with function code 5 go to VBR+4·vector and then VBR+4·vector+2. `pc_out` becomes {first, second}, `ssp_out` becomes SSP-8, and `done` is high for exactly one cycle.
- R9: A bus error on the acknowledge read sets `error`, which holds until the next accepted request. No further access follows, `pc_out` and `ssp_out` keep their values, and `done` stays low.
- R10: After reset, `busy`, `bus_req`, `done` and `error` are low, and `sr_out`, `pc_out` and `ssp_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Exception request |
| is_irq | input | 1 | 1 = interrupt, 0 = internal exception |
| irq_level | input | 3 | Level of the interrupt being taken |
| int_vector | input | 8 | Vector number for internal exceptions |
| sr_in | input | 16 | Current status word |
| pc_in | input | 32 | Current program counter |
| ssp_in | input | 32 | Current supervisor stack pointer |
| vbr_in | input | 32 | Vector base register |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_fc | output | 3 | Function code of the access |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with ack |
| bus_ack | input | 1 | Access complete |
| bus_err | input | 1 | Bus error, qualified by ack |
| sr_out | output | 16 | Updated status word |
| pc_out | output | 32 | Updated program counter |
| ssp_out | output | 32 | Updated supervisor stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: handler address loaded |
| error | output | 1 | Acknowledge read ended in bus error |

## Verification
The bench alternates interrupts and internal exceptions with random status words, levels, vector numbers, stack pointers, table bases and acknowledge delays. Comparing the two kinds shows whether the acknowledge read appears only for interrupts and whether the mask changes only for them. Random status words with the trace and supervisor bits in every combination show that the frame carries the copy taken before modification, while `sr_out` carries the modified value. Directed cases cover vector 0 and 255, a request held across a running sequence, and a bus error on the acknowledge read.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        is_irq,
  input  logic [2:0]  irq_level,
  input  logic [7:0]  int_vector,
  input  logic [15:0] sr_in,
  input  logic [31:0] pc_in,
  input  logic [31:0] ssp_in,
  input  logic [31:0] vbr_in,
  output logic        bus_req,
  output logic        bus_we,
  output logic [2:0]  bus_fc,
  output logic [31:0] bus_addr,
  output logic [15:0] bus_wdata,
  input  logic [15:0] bus_rdata,
  input  logic        bus_ack,
  input  logic        bus_err,
  output logic [15:0] sr_out,
  output logic [31:0] pc_out,
  output logic [31:0] ssp_out,
  output logic        busy,
  output logic        done,
  output logic        error
);
  localparam logic [2:0] FC_CPU  = 3'd7;
  localparam logic [2:0] FC_SDAT = 3'd5;
  localparam logic [3:0] FMT0    = 4'b0000;

  typedef enum logic [3:0] {
    S_IDLE, S_MODE, S_IACK, S_W0, S_W1, S_W2, S_W3, S_RH, S_RL
  } st_t;

  st_t         st;
  logic [15:0] sr_cp, hi_q;
  logic [31:0] pc_q, ssp_q, vbr_q;
  logic        irq_q;
  logic [2:0]  lvl_q;
  logic [7:0]  vec_q;

  wire [31:0] vaddr = vbr_q + {22'd0, vec_q, 2'b00};
  wire [15:0] fmt_w = {FMT0, 2'b00, vec_q, 2'b00};

  assign busy = (st != S_IDLE);

  always_comb begin
    bus_req   = 1'b1;
    bus_we    = 1'b0;
    bus_fc    = FC_SDAT;
    bus_addr  = 32'd0;
    bus_wdata = 16'd0;
    case (st)
      S_IACK: begin bus_fc = FC_CPU; bus_addr = {12'h000, 4'hF, 12'h000, lvl_q, 1'b1}; end
      S_W0:   begin bus_we = 1'b1; bus_addr = ssp_q - 32'd2; bus_wdata = fmt_w; end
      S_W1:   begin bus_we = 1'b1; bus_addr = ssp_q - 32'd4; bus_wdata = pc_q[15:0]; end
      S_W2:   begin bus_we = 1'b1; bus_addr = ssp_q - 32'd6; bus_wdata = pc_q[31:16]; end
      S_W3:   begin bus_we = 1'b1; bus_addr = ssp_q - 32'd8; bus_wdata = sr_cp; end
      S_RH:   bus_addr = vaddr;
      S_RL:   bus_addr = vaddr + 32'd2;
      default: bus_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sr_cp   <= '0;
      hi_q    <= '0;
      pc_q    <= '0;
      ssp_q   <= '0;
      vbr_q   <= '0;
      irq_q   <= 1'b0;
      lvl_q   <= '0;
      vec_q   <= '0;
      sr_out  <= '0;
      pc_out  <= '0;
      ssp_out <= '0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          sr_cp <= sr_in;
          pc_q  <= pc_in;
          ssp_q <= ssp_in;
          vbr_q <= vbr_in;
          irq_q <= is_irq;
          lvl_q <= irq_level;
          vec_q <= int_vector;
          error <= 1'b0;
          st    <= S_MODE;
        end
        S_MODE: begin
          sr_out <= {2'b00, 1'b1, sr_cp[12:11], irq_q ? lvl_q : sr_cp[10:8], sr_cp[7:0]};
          st     <= irq_q ? S_IACK : S_W0;
        end
        S_IACK: if (bus_ack) begin
          if (bus_err) begin
            error <= 1'b1;
            st    <= S_IDLE;
          end else begin
            vec_q <= bus_rdata[7:0];
            st    <= S_W0;
          end
        end
        S_W0: if (bus_ack) st <= S_W1;
        S_W1: if (bus_ack) st <= S_W2;
        S_W2: if (bus_ack) st <= S_W3;
        S_W3: if (bus_ack) st <= S_RH;
        S_RH: if (bus_ack) begin
          hi_q <= bus_rdata;
          st   <= S_RL;
        end
        S_RL: if (bus_ack) begin
          pc_out  <= {hi_q, bus_rdata};
          ssp_out <= ssp_q - 32'd8;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module exc_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_we,
  input logic [2:0]  bus_fc,
  input logic [31:0] bus_addr,
  input logic [15:0] bus_wdata,
  input logic        bus_ack,
  input logic [15:0] sr_out,
  input logic [31:0] pc_out,
  input logic        busy,
  input logic        done,
  input logic        error
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                            && $stable(bus_fc) && $stable(bus_wdata));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_mode_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sr_out[13] && sr_out[15:14] == 2'b00);
  p_iack_is_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_fc == 3'd7 |-> !bus_we);
  p_err_keeps_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> pc_out == $past(pc_out) && !done);
  p_bus_only_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (.*);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, is_irq = 1'b0;
  logic [2:0]  irq_level = '0;
  logic [7:0]  int_vector = '0;
  logic [15:0] sr_in = '0;
  logic [31:0] pc_in = '0, ssp_in = '0, vbr_in = '0;
  logic        bus_req, bus_we;
  logic [2:0]  bus_fc;
  logic [31:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ack = 1'b0, bus_err = 1'b0;
  logic [15:0] sr_out;
  logic [31:0] pc_out, ssp_out;
  logic        busy, done, error;

  exc_entry_seq u_dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int n_tx = 0, n_done = 0, n_errp = 0, wait_cnt = 0;
  logic [31:0] la [0:15];
  logic        lw [0:15];
  logic [2:0]  lf [0:15];
  logic [15:0] ld [0:15];
  logic [7:0]  iack_vec = '0;
  logic        iack_err = 1'b0;

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] exp_sr(input logic [15:0] s, input logic irq, input logic [2:0] lv);
    logic [15:0] r;
    r = (s | 16'h2000) & 16'h3FFF;
    if (irq) r[10:8] = lv;
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (done) n_done++;
    if (error && !$past(error)) n_errp++;
    if (bus_ack) begin
      bus_ack = 1'b0;
      bus_err = 1'b0;
    end else if (bus_req) begin
      if (wait_cnt == 0) begin
        if (n_tx < 16) begin
          la[n_tx] = bus_addr; lw[n_tx] = bus_we; lf[n_tx] = bus_fc; ld[n_tx] = bus_wdata;
        end
        n_tx++;
        bus_ack = 1'b1;
        if (bus_fc == 3'd7) begin
          bus_rdata = {8'h00, iack_vec};
          bus_err = iack_err;
        end else bus_rdata = mem_word(bus_addr);
        wait_cnt = $urandom % 3;
      end else wait_cnt--;
    end
  end

  always @(negedge clk) if (cycles > 150000) begin
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic run(input logic irq, input logic [2:0] lv, input logic [7:0] ivec,
                     input logic [7:0] avec, input logic [15:0] s, input logic [31:0] pc,
                     input logic [31:0] sp, input logic [31:0] vb, input int hold);
    logic [7:0]  v;
    logic [31:0] va, pc_prev;
    int base, d0;
    v = irq ? avec : ivec;
    va = vb + {22'd0, v, 2'b00};
    pc_prev = pc_out;
    @(negedge clk);
    n_tx = 0; d0 = n_done;
    is_irq = irq; irq_level = lv; int_vector = ivec; iack_vec = avec;
    sr_in = s; pc_in = pc; ssp_in = sp; vbr_in = vb; req = 1'b1;
    repeat (hold) @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 200 && n_done == d0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_done == d0 + 1, "R8 done count", n_done - d0, 1);
    chk(!busy, "R1 busy after done", busy, 0);
    chk(n_tx == (irq ? 7 : 6), "R4 access count", n_tx, irq ? 7 : 6);
    base = irq ? 1 : 0;
    if (irq)
      chk(la[0] == (32'h000F0001 | {28'd0, lv, 1'b0}) && lf[0] == 3'd7 && !lw[0],
          "R4 iack address", la[0], 32'h000F0001 | {28'd0, lv, 1'b0});
    chk(la[base] == sp - 2 && lw[base] && lf[base] == 3'd5, "R5 write0 addr", la[base], sp - 2);
    chk(ld[base] == {4'b0000, 2'b00, v, 2'b00}, "R6 format word", {16'd0, ld[base]}, {22'd0, v, 2'b00});
    chk(la[base+1] == sp - 4 && ld[base+1] == pc[15:0], "R5 pc low", {16'd0, ld[base+1]}, {16'd0, pc[15:0]});
    chk(la[base+2] == sp - 6 && ld[base+2] == pc[31:16], "R5 pc high", {16'd0, ld[base+2]}, {16'd0, pc[31:16]});
    chk(la[base+3] == sp - 8 && ld[base+3] == s && lw[base+3], "R5 saved sr", {16'd0, ld[base+3]}, {16'd0, s});
    chk(la[base+4] == va && !lw[base+4] && lf[base+4] == 3'd5, "R8 table hi addr", la[base+4], va);
    chk(la[base+5] == va + 2 && !lw[base+5], "R8 table lo addr", la[base+5], va + 2);
    chk(pc_out == {mem_word(va), mem_word(va + 2)}, "R8 pc_out", pc_out, {mem_word(va), mem_word(va + 2)});
    chk(ssp_out == sp - 8, "R8 ssp_out", ssp_out, sp - 8);
    chk(sr_out == exp_sr(s, irq, lv), irq ? "R3 sr_out mask" : "R2 sr_out", {16'd0, sr_out}, {16'd0, exp_sr(s, irq, lv)});
    if (pc_prev == 32'hDEAD_BEEF) $display("note");
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    chk(!busy && !bus_req && !done && !error, "R10 reset flags", {busy, bus_req, done, error}, 0);
    chk(pc_out == 0 && ssp_out == 0 && sr_out == 0, "R10 reset regs", pc_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(1'b0, 3'd0, 8'd0,   8'd0,   16'hC700, 32'h1234_5678, 32'h0000_8000, 32'h0000_0000, 1);
    run(1'b0, 3'd5, 8'd255, 8'd0,   16'h0000, 32'hFFFF_FFFE, 32'h0010_0000, 32'h0000_1000, 1);
    run(1'b1, 3'd7, 8'd9,   8'd255, 16'h8000, 32'h0000_0400, 32'h0000_0010, 32'h0000_0400, 1);
    run(1'b1, 3'd1, 8'd0,   8'd0,   16'hFFFF, 32'hAAAA_5554, 32'h2000_0000, 32'hFFFF_F000, 1);
    run(1'b0, 3'd2, 8'd3,   8'd0,   16'h2300, 32'h0000_1000, 32'h0000_4000, 32'h0000_0000, 6);
    for (int k = 0; k < 40; k++)
      run($urandom % 2, 3'($urandom), 8'($urandom), 8'($urandom), 16'($urandom),
          {$urandom} & 32'hFFFF_FFFE, {$urandom} & 32'hFFFF_FFFE, {$urandom} & 32'hFFFF_FFFC, 1);
    begin
      logic [31:0] pc_prev, sp_prev;
      int e0;
      pc_prev = pc_out; sp_prev = ssp_out; e0 = n_errp;
      @(negedge clk);
      n_tx = 0; iack_err = 1'b1; is_irq = 1'b1; irq_level = 3'd4; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      for (int i = 0; i < 50 && n_errp == e0; i++) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(error, "R9 error flag", error, 1);
      chk(n_tx == 1, "R9 no further access", n_tx, 1);
      chk(pc_out == pc_prev && ssp_out == sp_prev, "R9 pc kept", pc_out, pc_prev);
      chk(!busy, "R9 idle", busy, 0);
      iack_err = 1'b0;
      run(1'b0, 3'd0, 8'd17, 8'd0, 16'h0700, 32'h0000_2222, 32'h0000_9000, 32'h0000_0100, 1);
      chk(!error, "R9 error cleared", error, 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule